// File: doc/BRIEF.md
# IOTLB Invalidation Request Encoder

This block turns one IOTLB flush request into a single 128-bit invalidation descriptor, split into a low and a high 64-bit word and ready to be written into an invalidation queue. A request carries a domain identifier, a virtual address, a page count, an invalidation hint and a requested granularity: global, domain or page. Capability inputs report whether page-selective invalidation is supported, the largest address-mask value the hardware accepts, and whether read and write draining are supported.

A page request looks for the smallest address mask whose naturally aligned block of 2^mask pages covers the whole range. The search tries one mask value per clock cycle, starting at zero. A page request falls back to a domain-wide flush in three cases: page-selective support is absent, the address has page-offset bits set, or no mask up to the maximum covers the range. A granularity code with no meaning is rejected with a one-cycle error pulse. The descriptor leaves through a valid/ready handshake. Writing it into the queue is handled elsewhere.

Top module: `iotlb_inv_encoder`

## Requirements
- R1: Every descriptor carries type code 2 in low-word bits 3:0 and the granularity code in low-word bits 5:4. The codes are 1 = global, 2 = domain, 3 = page.
- R2: Low-word bit 7 (drain reads) equals the read-drain capability and bit 6 (drain writes) equals the write-drain capability, both sampled when the request is accepted.
- R3: A global request gives granularity 1, zero in the domain field (low bits 31:16) and an all-zero high word.
- R4: A domain request gives granularity 2, the request domain in low bits 31:16 and an all-zero high word.
- R5: A page request becomes a domain descriptor (granularity 2, high word zero) without any search when page-selective support is off or address bits 11:0 are nonzero.
- R6: An eligible page request emits granularity 3 with the smallest mask m satisfying (page number mod 2^m) + count <= 2^m. Its high word is the page-aligned address ORed with the hint at bit 6 and m in bits 5:0.
- R7: If no mask from 0 to the maximum-mask capability satisfies R6, a domain descriptor is emitted.
- R8: Granularity code 0 produces a one-cycle pulse on `req_error` in the cycle after acceptance, and no descriptor.
- R9: With the output free, a global, domain or ineligible page request shows `dsc_valid` one cycle after acceptance. A page request that fits at mask m shows it m+2 cycles after acceptance, and a fallback shows it max+2 cycles after acceptance. `req_ready` is low during a search and while a descriptor is waiting.
- R10: While `dsc_valid` is high and `dsc_ready` is low, the descriptor words and `dsc_valid` hold steady.
- R11: After reset, `dsc_valid` and `req_error` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_domain | input | DOM_W | Domain identifier |
| req_addr | input | ADDR_W | Virtual address of the first page |
| req_count | input | CNT_W | Number of pages |
| req_hint | input | 1 | Invalidation hint |
| req_gran | input | 2 | Requested granularity code |
| cap_psi | input | 1 | Page-selective invalidation supported |
| cap_max_am | input | AM_W | Largest permitted address mask |
| cap_drain_rd | input | 1 | Read draining supported |
| cap_drain_wr | input | 1 | Write draining supported |
| dsc_valid | output | 1 | Descriptor available |
| dsc_ready | input | 1 | Downstream takes the descriptor |
| dsc_lo | output | 64 | Descriptor low word |
| dsc_hi | output | 64 | Descriptor high word |
| req_error | output | 1 | Invalid granularity pulse |

## Verification
A corrupted mask counter or stale latched request shows up at the ports as a wrong mask in the high word or as an unexpected fallback to a domain descriptor, on the very descriptor being built. A stuck search state shows as `req_ready` staying low and a missing descriptor, which the latency checks catch within max+2 cycles. A broken output register shows as a changed or dropped word under backpressure, which the scoreboard detects on the next handshake.

// File: rtl/iotlb_enc_pkg.sv
package iotlb_enc_pkg;
  localparam int DSC_W = 64;
  localparam logic [3:0] IOTLB_TYPE = 4'd2;

  typedef enum logic [1:0] {
    GR_BAD    = 2'd0,
    GR_GLOBAL = 2'd1,
    GR_DOMAIN = 2'd2,
    GR_PAGE   = 2'd3
  } gran_e;

  typedef enum logic {
    S_IDLE   = 1'b0,
    S_SEARCH = 1'b1
  } enc_state_e;
endpackage

// File: rtl/iotlb_am_fit.sv
module iotlb_am_fit #(
  parameter int PFN_W = 52,
  parameter int CNT_W = 16,
  parameter int AM_W  = 6
) (
  input  logic [PFN_W-1:0] pfn,
  input  logic [CNT_W-1:0] count,
  input  logic [AM_W-1:0]  am,
  output logic             fits
);
  localparam int SPAN_W = (1 << AM_W) + 1;

  logic [SPAN_W-1:0] blk;
  logic [SPAN_W-1:0] offs;
  logic [SPAN_W-1:0] need;

  always_comb begin
    blk  = SPAN_W'(1) << am;
    offs = SPAN_W'(pfn) & (blk - SPAN_W'(1));
    need = offs + SPAN_W'(count);
    fits = (need <= blk);
  end
endmodule

// File: rtl/iotlb_desc_build.sv
module iotlb_desc_build
  import iotlb_enc_pkg::*;
#(
  parameter int DOM_W      = 16,
  parameter int ADDR_W     = 64,
  parameter int AM_W       = 6,
  parameter int PAGE_SHIFT = 12
) (
  input  gran_e              gran,
  input  logic [DOM_W-1:0]   dom,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               hint,
  input  logic [AM_W-1:0]    am,
  input  logic               drain_rd,
  input  logic               drain_wr,
  output logic [DSC_W-1:0]   lo,
  output logic [DSC_W-1:0]   hi
);
  localparam logic [DSC_W-1:0] OFFS_MASK = DSC_W'((64'd1 << PAGE_SHIFT) - 64'd1);

  logic [DOM_W-1:0] dom_eff;

  always_comb begin
    dom_eff = (gran == GR_GLOBAL) ? '0 : dom;
    lo = (DSC_W'(dom_eff) << 16)
       | (DSC_W'(drain_rd) << 7)
       | (DSC_W'(drain_wr) << 6)
       | (DSC_W'(gran) << 4)
       | DSC_W'(IOTLB_TYPE);
    if (gran == GR_PAGE) begin
      hi = (DSC_W'(addr) & ~OFFS_MASK) | (DSC_W'(hint) << 6) | DSC_W'(am);
    end else begin
      hi = '0;
    end
  end
endmodule

// File: rtl/iotlb_out_stage.sv
module iotlb_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] hi_in,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      lo    <= '0;
      hi    <= '0;
    end else if (load) begin
      valid <= 1'b1;
      lo    <= lo_in;
      hi    <= hi_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(lo) && $stable(hi)));

  assert_load_empty_R9: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid);
endmodule

// File: rtl/iotlb_inv_encoder.sv
module iotlb_inv_encoder
  import iotlb_enc_pkg::*;
#(
  parameter int DOM_W      = 16,
  parameter int ADDR_W     = 64,
  parameter int CNT_W      = 16,
  parameter int AM_W       = 6,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DOM_W-1:0]  req_domain,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_hint,
  input  logic [1:0]        req_gran,
  input  logic              cap_psi,
  input  logic [AM_W-1:0]   cap_max_am,
  input  logic              cap_drain_rd,
  input  logic              cap_drain_wr,
  output logic              dsc_valid,
  input  logic              dsc_ready,
  output logic [63:0]       dsc_lo,
  output logic [63:0]       dsc_hi,
  output logic              req_error
);
  localparam int PFN_W = ADDR_W - PAGE_SHIFT;

  enc_state_e        state;
  logic [AM_W-1:0]   am_q;
  logic [AM_W-1:0]   max_q;
  logic [DOM_W-1:0]  dom_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hint_q;
  logic              dr_q;
  logic              dw_q;

  gran_e             gran_in;
  logic              accept;
  logic              page_ok;
  logic              fits;
  logic              at_max;
  logic              load;

  gran_e             b_gran;
  logic [DOM_W-1:0]  b_dom;
  logic [ADDR_W-1:0] b_addr;
  logic              b_hint;
  logic [AM_W-1:0]   b_am;
  logic              b_dr;
  logic              b_dw;
  logic [63:0]       b_lo;
  logic [63:0]       b_hi;

  assign gran_in   = gran_e'(req_gran);
  assign req_ready = (state == S_IDLE) && !dsc_valid;
  assign accept    = req_valid && req_ready;
  assign page_ok   = cap_psi && (req_addr[PAGE_SHIFT-1:0] == '0);
  assign at_max    = (am_q == max_q);

  iotlb_am_fit #(.PFN_W(PFN_W), .CNT_W(CNT_W), .AM_W(AM_W)) u_fit (
    .pfn   (addr_q[ADDR_W-1:PAGE_SHIFT]),
    .count (cnt_q),
    .am    (am_q),
    .fits  (fits)
  );

  always_comb begin
    if (state == S_IDLE) begin
      b_gran = (gran_in == GR_PAGE) ? GR_DOMAIN : gran_in;
      b_dom  = req_domain;
      b_addr = req_addr;
      b_hint = req_hint;
      b_am   = '0;
      b_dr   = cap_drain_rd;
      b_dw   = cap_drain_wr;
      load   = accept && ((gran_in == GR_GLOBAL) || (gran_in == GR_DOMAIN) ||
                          ((gran_in == GR_PAGE) && !page_ok));
    end else begin
      b_gran = fits ? GR_PAGE : GR_DOMAIN;
      b_dom  = dom_q;
      b_addr = addr_q;
      b_hint = hint_q;
      b_am   = am_q;
      b_dr   = dr_q;
      b_dw   = dw_q;
      load   = fits || at_max;
    end
  end

  iotlb_desc_build #(.DOM_W(DOM_W), .ADDR_W(ADDR_W), .AM_W(AM_W),
                     .PAGE_SHIFT(PAGE_SHIFT)) u_build (
    .gran     (b_gran),
    .dom      (b_dom),
    .addr     (b_addr),
    .hint     (b_hint),
    .am       (b_am),
    .drain_rd (b_dr),
    .drain_wr (b_dw),
    .lo       (b_lo),
    .hi       (b_hi)
  );

  iotlb_out_stage #(.W(64)) u_out (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .lo_in (b_lo),
    .hi_in (b_hi),
    .ready (dsc_ready),
    .valid (dsc_valid),
    .lo    (dsc_lo),
    .hi    (dsc_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      am_q      <= '0;
      max_q     <= '0;
      dom_q     <= '0;
      addr_q    <= '0;
      cnt_q     <= '0;
      hint_q    <= 1'b0;
      dr_q      <= 1'b0;
      dw_q      <= 1'b0;
      req_error <= 1'b0;
    end else begin
      req_error <= accept && (gran_in == GR_BAD);
      if (state == S_IDLE) begin
        if (accept) begin
          dom_q  <= req_domain;
          addr_q <= req_addr;
          cnt_q  <= req_count;
          hint_q <= req_hint;
          dr_q   <= cap_drain_rd;
          dw_q   <= cap_drain_wr;
          max_q  <= cap_max_am;
          am_q   <= '0;
          if ((gran_in == GR_PAGE) && page_ok) begin
            state <= S_SEARCH;
          end
        end
      end else begin
        if (fits || at_max) begin
          state <= S_IDLE;
        end else begin
          am_q <= am_q + AM_W'(1);
        end
      end
    end
  end

  assert_type_R1: assert property (@(posedge clk) disable iff (rst)
    dsc_valid |-> (dsc_lo[3:0] == 4'h2 && dsc_lo[5:4] != 2'd0));

  assert_global_R3: assert property (@(posedge clk) disable iff (rst)
    (dsc_valid && dsc_lo[5:4] == 2'd1) |-> (dsc_lo[31:16] == 16'h0 && dsc_hi == 64'h0));

  assert_domain_hi_R4: assert property (@(posedge clk) disable iff (rst)
    (dsc_valid && dsc_lo[5:4] == 2'd2) |-> (dsc_hi == 64'h0));

  assert_mask_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (dsc_valid && dsc_lo[5:4] == 2'd3) |-> (dsc_hi[5:0] <= 6'(max_q)));

  assert_search_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_SEARCH) |-> (am_q <= max_q));

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_SEARCH) |-> !req_ready);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    req_error |-> !dsc_valid);
endmodule

// File: tb/sim_iotlb_inv_encoder.sv
`timescale 1ns/1ps
module sim_iotlb_inv_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_domain = '0;
  logic [63:0] req_addr = '0;
  logic [15:0] req_count = '0;
  logic        req_hint = 1'b0;
  logic [1:0]  req_gran = '0;
  logic        cap_psi = 1'b1;
  logic [5:0]  cap_max_am = 6'd4;
  logic        cap_drain_rd = 1'b1;
  logic        cap_drain_wr = 1'b0;
  logic        dsc_valid;
  logic        dsc_ready;
  logic [63:0] dsc_lo;
  logic [63:0] dsc_hi;
  logic        req_error;

  logic        bp_en = 1'b0;
  logic [7:0]  cyc = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  typedef struct {
    logic [63:0] lo;
    logic [63:0] hi;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 8'd1;
  assign dsc_ready = !bp_en || cyc[1];

  iotlb_inv_encoder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_domain(req_domain), .req_addr(req_addr), .req_count(req_count),
    .req_hint(req_hint), .req_gran(req_gran), .cap_psi(cap_psi),
    .cap_max_am(cap_max_am), .cap_drain_rd(cap_drain_rd),
    .cap_drain_wr(cap_drain_wr), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
    .dsc_lo(dsc_lo), .dsc_hi(dsc_hi), .req_error(req_error)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Reference model written from the requirements.
  function automatic void model(input logic [15:0] dom, input logic [63:0] addr,
                                input logic [15:0] cnt, input logic hint,
                                input logic [1:0] gran, output logic [63:0] lo,
                                output logic [63:0] hi, output int lat);
    logic [1:0]  g;
    logic [64:0] blk;
    logic [64:0] offs;
    bit          found;
    g = gran;
    hi = '0;
    lat = 1;
    found = 0;
    if (g == 2'd3) begin
      if (!cap_psi || addr[11:0] != 12'h0) begin
        g = 2'd2;
      end else begin
        for (int m = 0; m <= int'(cap_max_am); m++) begin
          if (!found) begin
            blk  = 65'd1 << m;
            offs = 65'(addr[63:12]) % blk;
            if (offs + 65'(cnt) <= blk) begin
              found = 1;
              lat = m + 2;
              hi = {addr[63:12], 12'h0} | (64'(hint) << 6) | 64'(m);
            end
          end
        end
        if (!found) begin
          g = 2'd2;
          lat = int'(cap_max_am) + 2;
        end
      end
    end
    lo = (64'(g == 2'd1 ? 16'h0 : dom) << 16) | (64'(cap_drain_rd) << 7) |
         (64'(cap_drain_wr) << 6) | (64'(g) << 4) | 64'h2;
  endfunction

  int last_lat;

  task automatic send(input logic [15:0] dom, input logic [63:0] addr,
                      input logic [15:0] cnt, input logic hint,
                      input logic [1:0] gran, input string tag);
    exp_t e;
    model(dom, addr, cnt, hint, gran, e.lo, e.hi, last_lat);
    e.tag = tag;
    if (gran != 2'd0) exp_q.push_back(e);
    @(negedge clk);
    req_domain = dom; req_addr = addr; req_count = cnt;
    req_hint = hint; req_gran = gran; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic send_timed(input logic [15:0] dom, input logic [63:0] addr,
                            input logic [15:0] cnt, input logic hint,
                            input logic [1:0] gran, input string tag);
    int n;
    send(dom, addr, cnt, hint, gran, tag);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      n++;
      if (n == 1 && last_lat > 1)
        check(!req_ready, {tag, " R9 ready low during search"}, 64'(req_ready), 64'd0);
      if (dsc_valid) break;
    end
    check(n == last_lat, {tag, " R9 latency"}, 64'(n), 64'(last_lat));
  endtask

  task automatic drain();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !dsc_valid) break;
    end
  endtask

  // Scoreboard monitor: compare each handed-off descriptor.
  logic        hold_pend = 1'b0;
  logic [63:0] hold_lo, hold_hi;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        check(dsc_valid && dsc_lo == hold_lo && dsc_hi == hold_hi,
              "R10 hold under backpressure", dsc_lo, hold_lo);
      end
      hold_pend = dsc_valid && !dsc_ready;
      hold_lo = dsc_lo;
      hold_hi = dsc_hi;
      if (dsc_valid && dsc_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected descriptor", dsc_lo, 64'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(dsc_lo == e.lo, {e.tag, " low word"}, dsc_lo, e.lo);
          check(dsc_hi == e.hi, {e.tag, " high word"}, dsc_hi, e.hi);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!dsc_valid && req_ready && !req_error, "R11 reset state",
          {61'h0, dsc_valid, req_ready, req_error}, 64'h2);

    // R3 / R2: global with read drain only
    send_timed(16'h1234, 64'h0, 16'd0, 1'b0, 2'd1, "R3 R2 global");
    drain();
    // R4: domain
    send_timed(16'hBEEF, 64'h7000, 16'd1, 1'b1, 2'd2, "R4 domain");
    drain();
    // R6: single page, mask 0
    send_timed(16'h0042, 64'h5000, 16'd1, 1'b1, 2'd3, "R6 page mask0");
    drain();
    // R6: page number 3, two pages -> mask 3
    send_timed(16'h0043, 64'h3000, 16'd2, 1'b0, 2'd3, "R6 page mask3");
    drain();
    // R5: misaligned address
    send_timed(16'h0044, 64'h5008, 16'd1, 1'b0, 2'd3, "R5 misaligned");
    drain();
    // R7: range too large for max mask 4
    send_timed(16'h0045, 64'h0, 16'd100, 1'b0, 2'd3, "R7 fallback");
    drain();
    // R7: mask 3 needed but max 2
    cap_max_am = 6'd2;
    send_timed(16'h0046, 64'h3000, 16'd2, 1'b1, 2'd3, "R7 max limit");
    drain();
    // R5 / R2: no page-selective support, write drain only
    cap_psi = 1'b0; cap_drain_rd = 1'b0; cap_drain_wr = 1'b1; cap_max_am = 6'd5;
    send_timed(16'h0047, 64'h9000, 16'd1, 1'b0, 2'd3, "R5 R2 no psi");
    drain();

    // R8: invalid granularity
    cap_psi = 1'b1;
    send(16'h0048, 64'h1000, 16'd1, 1'b0, 2'd0, "R8 bad gran");
    @(negedge clk);
    check(req_error == 1'b1, "R8 error pulse", 64'(req_error), 64'd1);
    @(negedge clk);
    check(req_error == 1'b0, "R8 pulse one cycle", 64'(req_error), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!dsc_valid, "R8 no descriptor", 64'(dsc_valid), 64'd0);
    end

    // R1 / R10: mixed stream under backpressure
    bp_en = 1'b1;
    cap_drain_rd = 1'b1;
    for (int i = 0; i < 20; i++) begin
      send(16'(i * 7), (i % 5 == 0) ? 64'(i * 4096 + 16) : 64'(i * 4096),
           16'((i * 3) % 17), i[0], 2'((i % 3) + 1), "R1 stream");
    end
    drain();
    bp_en = 1'b0;
    drain();
    check(exp_q.size() == 0, "R1 all descriptors delivered", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule